// File: doc/BRIEF.md
# Error-Correction Engine Register Block

This block is the register front end of an error-correction engine whose encoder and decoder halves work independently. Each half has a fixed bank of registers: a run bit, a configuration word, an idle flag, an interrupt mask bit and a status bit that clears when it is read. Software fills the configuration while the half is stopped, sets the run bit and then waits. It can poll the idle flag or wait for the interrupt line. Afterwards it reads the result: parity words for the encoder, or a per-sector completion bitmap and packed per-sector error counts for the decoder.

The correction arithmetic itself is not part of this block. Behavioural stand-ins model the two halves. They take a fixed number of cycles and return results that follow fixed formulas, so that the register side can be built and checked on its own. The 5-bit strength code in the configuration word selects the correction strength. The encoder stand-in uses that strength to decide how many parity words hold data.

Top module: `ecc_regblock`

## Requirements
- R1: After reset both run bits read 0, both idle flags read 1, both status registers read 0 and `irq` is 0.
- R2: Writing 1 to bit 0 of a run register (encoder 0x000, decoder 0x100) starts that half if it was stopped. Its idle flag (bit 0 of 0x00C or 0x10C) then reads 0 until the operation ends, and reads 1 afterwards. An encode lasts LAT cycles. A decode lasts LAT+SECTORS-1 cycles.
- R3: When an encode ends, the parity word at 0x010+4*i holds cfg+i for i < ceil(S*PBITS/32) and 0 for every higher i. Here S is the strength selected by the configuration bits [4:0]: codes 0x00..0x0A give 4+2*code, codes 0x0B..0x13 give 28+4*(code-0x0B), and any other code gives 4.
- R4: A write to a configuration register (0x004 or 0x104) while that half's run bit is 1 leaves the register unchanged. A write while the run bit is 0 takes effect.
- R5: Starting a decode clears the completion bitmap at 0x124. Sector s sets bitmap bit s at clock edge start+LAT+s, so the sectors finish in ascending order.
- R6: The error count of sector s sits in byte lane s%4 of the word at 0x114+4*(s/4). Its value is (code+s) mod 64, or 0 when decoder configuration bit 31 (empty-page detection) is set.
- R7: A status bit (bit 0 of 0x084 or 0x204) is set when its half finishes. A read returns the current value and clears the bit. If a completion falls in the same cycle as the read, the read returns the old value and the bit remains 1.
- R8: `irq` is the registered OR, over both halves, of mask bit 0 (0x080 / 0x200) AND status bit. It follows the status one cycle later and stays 0 while the mask is 0.
- R9: Writing 0 to a running half's run register aborts the operation. Idle reads 1 on the next read, and no status, bitmap bit or result appears afterwards.
- R10: A read of any offset outside the register map returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Level interrupt |

## Verification
Two things can land on the same clock edge: a half finishing and setting its status, and a read clearing that status. The bench starts an encode and counts cycles so that its read of 0x084 is captured on exactly the edge where the operation ends. It expects three consecutive reads to return 0, 1 and 0, with `irq` rising after the second read and falling after the third. That sequence shows that the completion took priority and was neither lost nor reported twice.

// File: rtl/ecc_reg_pkg.sv
package ecc_reg_pkg;
  // Register offsets (byte addresses)
  localparam logic [11:0] OFF_ENC_CTRL = 12'h000;
  localparam logic [11:0] OFF_ENC_CFG  = 12'h004;
  localparam logic [11:0] OFF_ENC_IDLE = 12'h00C;
  localparam logic [11:0] OFF_ENC_PAR  = 12'h010;
  localparam logic [11:0] OFF_ENC_IEN  = 12'h080;
  localparam logic [11:0] OFF_ENC_STA  = 12'h084;
  localparam logic [11:0] OFF_DEC_CTRL = 12'h100;
  localparam logic [11:0] OFF_DEC_CFG  = 12'h104;
  localparam logic [11:0] OFF_DEC_IDLE = 12'h10C;
  localparam logic [11:0] OFF_DEC_ERR  = 12'h114;
  localparam logic [11:0] OFF_DEC_MAP  = 12'h124;
  localparam logic [11:0] OFF_DEC_IEN  = 12'h200;
  localparam logic [11:0] OFF_DEC_STA  = 12'h204;

  // Correction strength selected by a 5-bit code; unknown codes fall back to 4
  function automatic int unsigned strength_of(input logic [4:0] code);
    if (code <= 5'h0A) return 4 + 2 * 32'(code);
    else if (code <= 5'h13) return 28 + 4 * (32'(code) - 11);
    else return 4;
  endfunction

  // Number of 32-bit words the parity of a given strength occupies
  function automatic int unsigned parity_words(input logic [4:0] code,
                                               input int unsigned pbits);
    return (strength_of(code) * pbits + 31) / 32;
  endfunction
endpackage

// File: rtl/ecc_op_timer.sv
module ecc_op_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic [CW-1:0] limit,
  output logic          busy,
  output logic [CW-1:0] count,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      count <= '0;
    end else if (abort) begin
      busy  <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      count <= '0;
    end else if (busy) begin
      if (count == limit) busy <= 1'b0;
      else count <= count + 1'b1;
    end
  end

  assign last = busy && (count == limit) && !abort;

  // R9: an abort returns the half to idle on the next cycle
  a_r9_abort_idles: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy);
  // R2: a start makes the half busy from the first count
  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !abort) |=> (busy && count == '0));
endmodule

// File: rtl/ecc_sticky_status.sv
module ecc_sticky_status (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic rd_clr,
  output logic sta
);
  always_ff @(posedge clk) begin
    if (rst) sta <= 1'b0;
    else     sta <= set | (sta & ~rd_clr);
  end

  // R7: a completion is never lost, even when a read lands on the same edge
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    set |=> sta);
  // R7: a read with no completion leaves the bit cleared
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !set) |=> !sta);
endmodule

// File: rtl/ecc_enc_stub.sv
module ecc_enc_stub
  import ecc_reg_pkg::*;
#(
  parameter int LAT   = 16,
  parameter int PW    = 28,
  parameter int PBITS = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 abort,
  input  logic [31:0]          cfg,
  output logic                 busy,
  output logic                 done,
  output logic [PW-1:0][31:0]  parity
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] count;
  int unsigned   nwords;

  ecc_op_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .start(start), .abort(abort),
    .limit(CW'(LAT - 1)), .busy(busy), .count(count), .last(done)
  );

  assign nwords = parity_words(cfg[4:0], PBITS);

  always_ff @(posedge clk) begin
    if (rst) begin
      parity <= '0;
    end else if (done) begin
      for (int i = 0; i < PW; i++)
        parity[i] <= (i < int'(nwords)) ? cfg + 32'(i) : 32'h0;
    end
  end

  // R3: the top parity word beyond any strength stays clear after a run
  a_r3_top_word_clear: assert property (@(posedge clk) disable iff (rst)
    (done && nwords < PW) |=> parity[PW-1] == 32'h0);
endmodule

// File: rtl/ecc_dec_stub.sv
module ecc_dec_stub #(
  parameter int LAT     = 16,
  parameter int SECTORS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       abort,
  input  logic [4:0]                 code,
  input  logic                       empty_en,
  output logic                       busy,
  output logic                       done,
  output logic [SECTORS-1:0]         map,
  output logic [SECTORS-1:0][7:0]    errs
);
  localparam int CW = $clog2(LAT + SECTORS + 1);

  logic [CW-1:0] count;
  logic [CW-1:0] sidx;
  logic          fire;

  ecc_op_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .start(start), .abort(abort),
    .limit(CW'(LAT + SECTORS - 2)), .busy(busy), .count(count), .last(done)
  );

  assign fire = busy && !abort && (count >= CW'(LAT - 1));
  assign sidx = count - CW'(LAT - 1);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      map  <= '0;
      errs <= '0;
    end else if (fire) begin
      for (int s = 0; s < SECTORS; s++) begin
        if (sidx == CW'(s)) begin
          map[s]  <= 1'b1;
          errs[s] <= empty_en ? 8'h00 : {2'b00, 6'(code) + 6'(s)};
        end
      end
    end
  end

  // R5: bitmap bits only accumulate until the next start
  a_r5_map_accumulates: assert property (@(posedge clk) disable iff (rst)
    !start |=> ((map & $past(map)) == $past(map)));
  // R5: at most one new sector per cycle
  a_r5_one_sector_step: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($countones(map) <= $countones($past(map)) + 1));
endmodule

// File: rtl/ecc_regblock.sv
module ecc_regblock
  import ecc_reg_pkg::*;
#(
  parameter int LAT     = 16,  // encoder cycles; decoder adds SECTORS-1
  parameter int SECTORS = 8,   // at most 16 so error words stay below 0x124
  parameter int PW      = 28,  // at most 28 so the window stays below 0x080
  parameter int PBITS   = 14
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int EW = (SECTORS + 3) / 4;

  logic        ctrl_e, ctrl_d, ien_e, ien_d;
  logic [31:0] cfg_e, cfg_d;
  logic        busy_e, busy_d, done_e, done_d, sta_e, sta_d;
  logic        start_e, start_d, abort_e, abort_d;
  logic [PW-1:0][31:0]      par;
  logic [SECTORS-1:0]       map;
  logic [SECTORS-1:0][7:0]  errs;
  logic [EW-1:0][31:0]      errw;
  logic [31:0] rd_val;
  logic        hit;

  // Run-bit edges drive the stand-ins
  assign start_e = bus_wr && bus_addr == OFF_ENC_CTRL &&  bus_wdata[0] && !ctrl_e;
  assign abort_e = bus_wr && bus_addr == OFF_ENC_CTRL && !bus_wdata[0] &&  ctrl_e;
  assign start_d = bus_wr && bus_addr == OFF_DEC_CTRL &&  bus_wdata[0] && !ctrl_d;
  assign abort_d = bus_wr && bus_addr == OFF_DEC_CTRL && !bus_wdata[0] &&  ctrl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_e <= 1'b0; ctrl_d <= 1'b0;
      ien_e  <= 1'b0; ien_d  <= 1'b0;
      cfg_e  <= '0;   cfg_d  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFF_ENC_CTRL: ctrl_e <= bus_wdata[0];
        OFF_DEC_CTRL: ctrl_d <= bus_wdata[0];
        OFF_ENC_IEN:  ien_e  <= bus_wdata[0];
        OFF_DEC_IEN:  ien_d  <= bus_wdata[0];
        OFF_ENC_CFG:  if (!ctrl_e) cfg_e <= bus_wdata;
        OFF_DEC_CFG:  if (!ctrl_d) cfg_d <= bus_wdata;
        default: ;
      endcase
    end
  end

  ecc_enc_stub #(.LAT(LAT), .PW(PW), .PBITS(PBITS)) u_enc (
    .clk(clk), .rst(rst), .start(start_e), .abort(abort_e), .cfg(cfg_e),
    .busy(busy_e), .done(done_e), .parity(par)
  );

  ecc_dec_stub #(.LAT(LAT), .SECTORS(SECTORS)) u_dec (
    .clk(clk), .rst(rst), .start(start_d), .abort(abort_d),
    .code(cfg_d[4:0]), .empty_en(cfg_d[31]),
    .busy(busy_d), .done(done_d), .map(map), .errs(errs)
  );

  ecc_sticky_status u_sta_e (
    .clk(clk), .rst(rst), .set(done_e),
    .rd_clr(bus_rd && bus_addr == OFF_ENC_STA), .sta(sta_e)
  );

  ecc_sticky_status u_sta_d (
    .clk(clk), .rst(rst), .set(done_d),
    .rd_clr(bus_rd && bus_addr == OFF_DEC_STA), .sta(sta_d)
  );

  // Pack per-sector counts four lanes to a word
  always_comb begin
    errw = '0;
    for (int j = 0; j < EW; j++)
      for (int k = 0; k < 4; k++)
        if (4 * j + k < SECTORS) errw[j][8*k +: 8] = errs[4*j + k];
  end

  always_comb begin
    rd_val = '0;
    hit    = 1'b1;
    case (bus_addr)
      OFF_ENC_CTRL: rd_val = {31'b0, ctrl_e};
      OFF_ENC_CFG:  rd_val = cfg_e;
      OFF_ENC_IDLE: rd_val = {31'b0, !busy_e};
      OFF_ENC_IEN:  rd_val = {31'b0, ien_e};
      OFF_ENC_STA:  rd_val = {31'b0, sta_e};
      OFF_DEC_CTRL: rd_val = {31'b0, ctrl_d};
      OFF_DEC_CFG:  rd_val = cfg_d;
      OFF_DEC_IDLE: rd_val = {31'b0, !busy_d};
      OFF_DEC_MAP:  rd_val = 32'(map);
      OFF_DEC_IEN:  rd_val = {31'b0, ien_d};
      OFF_DEC_STA:  rd_val = {31'b0, sta_d};
      default: begin
        hit = 1'b0;
        for (int i = 0; i < PW; i++)
          if (bus_addr == 12'(OFF_ENC_PAR + 4 * i)) begin
            rd_val = par[i];
            hit    = 1'b1;
          end
        for (int j = 0; j < EW; j++)
          if (bus_addr == 12'(OFF_DEC_ERR + 4 * j)) begin
            rd_val = errw[j];
            hit    = 1'b1;
          end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_val : 32'h0;
      irq       <= (ien_e & sta_e) | (ien_d & sta_d);
    end
  end

  // R4: configuration holds while its half is enabled
  a_r4_cfg_enc_locked: assert property (@(posedge clk) disable iff (rst)
    ctrl_e |=> $stable(cfg_e));
  a_r4_cfg_dec_locked: assert property (@(posedge clk) disable iff (rst)
    ctrl_d |=> $stable(cfg_d));
  // R8: the interrupt only follows an enabled, pending status
  a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past((ien_e && sta_e) || (ien_d && sta_d)));
  // R10: unmapped reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !hit) |=> bus_rdata == 32'h0);
  // R2: a stopped half is never busy
  a_r2_idle_when_stopped: assert property (@(posedge clk) disable iff (rst)
    !ctrl_e |-> !busy_e);
endmodule

// File: tb/ecc_regblock_tb.sv
`timescale 1ns/1ps
module ecc_regblock_tb;
  import ecc_reg_pkg::*;

  localparam int LAT = 16, SECTORS = 8, PW = 28, PBITS = 14;

  // {code, expected parity word count}
  localparam logic [9:0] VEC [7] = '{
    {5'h00, 5'd2}, {5'h05, 5'd7}, {5'h0A, 5'd11}, {5'h0B, 5'd13},
    {5'h10, 5'd21}, {5'h13, 5'd27}, {5'h1F, 5'd2}
  };

  logic        clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ecc_regblock #(.LAT(LAT), .SECTORS(SECTORS), .PW(PW), .PBITS(PBITS)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1; d = bus_rdata; bus_rd = 1'b0;
  endtask

  initial begin
    logic [31:0] v, cfg, expv, bad_act, bad_exp;
    int bad;
    repeat (3) @(posedge clk); #1 rst = 1'b0;

    // R1 reset state
    rd(OFF_ENC_CTRL, v); chk("R1 enc run", v, 0);
    rd(OFF_ENC_IDLE, v); chk("R1 enc idle", v, 1);
    rd(OFF_DEC_IDLE, v); chk("R1 dec idle", v, 1);
    rd(OFF_ENC_STA, v);  chk("R1 enc status", v, 0);
    rd(OFF_DEC_STA, v);  chk("R1 dec status", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R10 unmapped offsets
    rd(12'h008, v); chk("R10 0x008", v, 0);
    rd(12'h11C, v); chk("R10 0x11C", v, 0);
    rd(12'h3F0, v); chk("R10 0x3F0", v, 0);

    // R3 / R2 table of strength codes
    for (int n = 0; n < 7; n++) begin
      cfg = 32'h0200_0040 | 32'(VEC[n][9:5]);
      wr(OFF_ENC_CFG, cfg);
      wr(OFF_ENC_CTRL, 1);
      rd(OFF_ENC_IDLE, v); chk("R2 enc busy", v, 0);
      repeat (LAT + 4) @(posedge clk);
      rd(OFF_ENC_IDLE, v); chk("R2 enc idle after", v, 1);
      rd(OFF_ENC_STA, v);  chk("R7 enc status set", v, 1);
      bad = 0; bad_act = 0; bad_exp = 0;
      for (int i = 0; i < PW; i++) begin
        rd(12'(OFF_ENC_PAR + 4 * i), v);
        expv = (i < int'(VEC[n][4:0])) ? cfg + 32'(i) : 32'h0;
        if (v !== expv && bad == 0) begin bad_act = v; bad_exp = expv; end
        if (v !== expv) bad++;
      end
      chk("R3 parity window", bad_act, bad_exp);
      wr(OFF_ENC_CTRL, 0);
    end

    // R4 configuration lock, R9 encoder abort
    wr(OFF_ENC_CFG, 32'h1111_0001);
    wr(OFF_ENC_CTRL, 1);
    wr(OFF_ENC_CFG, 32'h2222_0002);
    rd(OFF_ENC_CFG, v); chk("R4 cfg held while enabled", v, 32'h1111_0001);
    wr(OFF_ENC_CTRL, 0);
    rd(OFF_ENC_IDLE, v); chk("R9 enc idle after abort", v, 1);
    wr(OFF_ENC_CFG, 32'h2222_0002);
    rd(OFF_ENC_CFG, v); chk("R4 cfg taken when stopped", v, 32'h2222_0002);
    repeat (LAT + 4) @(posedge clk);
    rd(OFF_ENC_STA, v); chk("R9 no enc status after abort", v, 0);

    // R7 / R8 completion and read on the same edge
    wr(OFF_ENC_IEN, 1);
    wr(OFF_ENC_CTRL, 1);
    repeat (LAT - 1) @(posedge clk);
    rd(OFF_ENC_STA, v); chk("R7 read on done edge returns old", v, 0);
    rd(OFF_ENC_STA, v); chk("R7 status kept after collision", v, 1);
    chk("R8 irq raised", {31'b0, irq}, 1);
    rd(OFF_ENC_STA, v); chk("R7 status cleared by read", v, 0);
    chk("R8 irq dropped", {31'b0, irq}, 0);
    wr(OFF_ENC_CTRL, 0);

    // R5 / R6 decoder ordering and counts
    wr(OFF_DEC_CFG, 32'h1000_3003);
    wr(OFF_DEC_CTRL, 1);
    repeat (LAT) @(posedge clk);
    rd(OFF_DEC_MAP, v); chk("R5 sector 0 first", v, 32'h01);
    rd(OFF_DEC_MAP, v); chk("R5 sector 1 next", v, 32'h03);
    rd(OFF_DEC_IDLE, v); chk("R2 dec busy", v, 0);
    repeat (SECTORS + 4) @(posedge clk);
    rd(OFF_DEC_MAP, v); chk("R5 all sectors", v, 32'hFF);
    chk("R8 masked irq stays low", {31'b0, irq}, 0);
    rd(OFF_DEC_ERR, v); chk("R6 counts word 0", v, 32'h0605_0403);
    rd(12'(OFF_DEC_ERR + 4), v); chk("R6 counts word 1", v, 32'h0A09_0807);
    rd(OFF_DEC_STA, v); chk("R7 dec status set", v, 1);
    rd(OFF_DEC_STA, v); chk("R7 dec status cleared", v, 0);
    wr(OFF_DEC_CTRL, 0);

    // R5 clear at start, R6 empty-page detection
    wr(OFF_DEC_CFG, 32'h8000_3003);
    wr(OFF_DEC_CTRL, 1);
    rd(OFF_DEC_MAP, v); chk("R5 bitmap cleared at start", v, 0);
    repeat (LAT + SECTORS + 4) @(posedge clk);
    rd(OFF_DEC_ERR, v); chk("R6 empty page counts zero", v, 0);
    wr(OFF_DEC_CTRL, 0);

    // R6 high code
    wr(OFF_DEC_CFG, 32'h0000_301F);
    wr(OFF_DEC_CTRL, 1);
    repeat (LAT + SECTORS + 4) @(posedge clk);
    rd(OFF_DEC_ERR, v); chk("R6 code 0x1F word 0", v, 32'h2221_201F);
    rd(12'(OFF_DEC_ERR + 4), v); chk("R6 code 0x1F word 1", v, 32'h2625_2423);
    rd(OFF_DEC_STA, v);
    wr(OFF_DEC_CTRL, 0);

    // R9 decoder abort
    wr(OFF_DEC_IEN, 1);
    wr(OFF_DEC_CTRL, 1);
    repeat (5) @(posedge clk);
    wr(OFF_DEC_CTRL, 0);
    rd(OFF_DEC_IDLE, v); chk("R9 dec idle after abort", v, 1);
    repeat (LAT + SECTORS + 4) @(posedge clk);
    rd(OFF_DEC_STA, v); chk("R9 no dec status", v, 0);
    rd(OFF_DEC_MAP, v); chk("R9 no sectors", v, 0);
    chk("R9 no irq", {31'b0, irq}, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule